// File: doc/BRIEF.md
# Coherence Directory Slice

This block is one slice of a directory that is split across several slices by address. Each slice tracks every cache line whose address hashes to it. For each line it records whether any private L2 cache holds the line, and if so which ones. A core that misses in its L2 sends the line address here. The slice then chooses where the data will come from. If another core's cache holds the line, the slice sends a forward request to that core. Otherwise it sends a read to one of the memory controllers, and the controller is picked from the address bits.

A request for exclusive ownership also causes an invalidate toward every other holder. The requester is acknowledged only when the memory read, the forward and every invalidate have been acknowledged back to the slice. The slice then rewrites the tracking entry and returns an acknowledgement to the requester. Only one transaction is open at a time. Requests that arrive while it is open wait in a small first-in first-out pending queue, so requests to the same line are served in the order they arrived.

Top module: `tag_dir_slice`

## Requirements
- R1: A request is accepted only when the XOR of the four 2-bit chunks of its 8-bit line address equals the slice number (0 by default). Any other request is dropped: it is not queued, and it produces no memory read, forward, invalidate or acknowledgement.
- R2: A memory read carries the line address and a controller select equal to the parity of line bits 7 down to 1.
- R3: When no core other than the requester holds the line, the slice issues a memory read. The exception is R7. The acknowledgement follows the memory acknowledgement.
- R4: When some other core holds the line, the slice forwards the request to the lowest-numbered such core. No memory read is issued, and the forward never targets the requester.
- R5: For an exclusive request, every other holder except the forward target receives an invalidate, shown as a one-hot-per-core mask with bit i for core i. The grant is held back until the forward and every invalidate have been acknowledged.
- R6: After a shared read, the holders of the line are the previous holders plus the requester. After an exclusive grant, the requester is the only holder.
- R7: An exclusive request from the sole current holder is granted without any memory read, forward or invalidate.
- R8: Accepted requests wait in a 4-entry pending queue and complete in arrival order. req_ready is low while the queue is full.
- R9: After reset every line is untracked, no request output or acknowledgement is active, and req_ready is high.
- R10: The acknowledgement is a one-cycle pulse. It carries the requester's core number, the line, and whether exclusive ownership was granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Pending queue can take a request |
| req_core | input | 2 | Requesting core |
| req_line | input | 8 | Line address of the miss |
| req_excl | input | 1 | 1 = exclusive ownership wanted |
| mem_valid | output | 1 | Memory read outstanding |
| mem_sel | output | 1 | Selected memory controller |
| mem_line | output | 8 | Line to read from memory |
| mem_ack | input | 1 | Memory read acknowledged |
| fwd_valid | output | 1 | Forward outstanding |
| fwd_core | output | 2 | Core asked to supply the line |
| fwd_line | output | 8 | Forwarded line |
| fwd_excl | output | 1 | Supplier must drop its copy |
| fwd_ack | input | 1 | Forward acknowledged |
| inv_valid | output | 1 | Invalidates outstanding |
| inv_mask | output | 4 | Cores still to acknowledge an invalidate |
| inv_line | output | 8 | Line being invalidated |
| inv_ack_valid | input | 1 | One invalidate acknowledged |
| inv_ack_core | input | 2 | Core acknowledging the invalidate |
| ack_valid | output | 1 | Completion pulse to requester |
| ack_core | output | 2 | Core being acknowledged |
| ack_line | output | 8 | Completed line |
| ack_excl | output | 1 | Exclusive ownership granted |

## Verification
Two pairs of events can land in the same cycle. The first pair is a forward acknowledgement and the first invalidate acknowledgement. The bench makes these coincide on every exclusive request that has both a supplier and extra sharers, and it requires that the grant does not appear while any invalidate is still owed. The second pair is the arrival of a new request and the pop of the queue head into the open slot. The bench provokes this by pushing back-to-back requests to one line, and it judges the result by the order of the acknowledgements and by the forward targets and invalidate masks that each queued request receives.

// File: rtl/tdir_pkg.sv
package tdir_pkg;
    localparam int N_CORES  = 4;
    localparam int CORE_W   = $clog2(N_CORES);
    localparam int LINE_W   = 8;
    localparam int N_SLICES = 4;
    localparam int SLICE_W  = $clog2(N_SLICES);
    localparam int N_MCS    = 2;
    localparam int MC_W     = $clog2(N_MCS);
    localparam int S_CHUNKS = (LINE_W + SLICE_W - 1) / SLICE_W;
    localparam int M_CHUNKS = (LINE_W - 1 + MC_W - 1) / MC_W;

    typedef enum logic [1:0] {DS_INV = 2'd0, DS_SHR = 2'd1, DS_EXC = 2'd2} dstate_e;

    typedef struct packed {
        logic [CORE_W-1:0] core;
        logic [LINE_W-1:0] line;
        logic              excl;
    } req_t;

    typedef struct packed {
        dstate_e            st;
        logic [CORE_W-1:0]  owner;
        logic [N_CORES-1:0] sharers;
    } dent_t;

    // Slice hash: XOR fold of the line address in SLICE_W-bit chunks.
    function automatic logic [SLICE_W-1:0] slice_of(input logic [LINE_W-1:0] l);
        logic [SLICE_W-1:0] acc;
        logic [LINE_W-1:0]  t;
        acc = '0;
        t   = l;
        for (int i = 0; i < S_CHUNKS; i++) begin
            acc = acc ^ t[SLICE_W-1:0];
            t   = t >> SLICE_W;
        end
        return acc;
    endfunction

    // Controller hash: XOR fold of the line bits above bit 0.
    function automatic logic [MC_W-1:0] mc_of(input logic [LINE_W-1:0] l);
        logic [MC_W-1:0]   acc;
        logic [LINE_W-1:0] t;
        acc = '0;
        t   = l >> 1;
        for (int i = 0; i < M_CHUNKS; i++) begin
            acc = acc ^ t[MC_W-1:0];
            t   = t >> MC_W;
        end
        return acc;
    endfunction

    function automatic logic [CORE_W-1:0] lowest_core(input logic [N_CORES-1:0] v);
        logic [CORE_W-1:0] r;
        r = '0;
        for (int i = N_CORES - 1; i >= 0; i--)
            if (v[i]) r = CORE_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/tdir_fifo.sv
module tdir_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) begin
                slots[wp] <= wr_data;
                wp        <= bump(wp);
            end
            if (rd_en) rp <= bump(rp);
            if (wr_en && !rd_en)      cnt <= cnt + 1'b1;
            else if (!wr_en && rd_en) cnt <= cnt - 1'b1;
        end
    end

    assign rd_data = slots[rp];
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign empty   = (cnt == '0);

    a_r8_push_counts: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_en) |=> (cnt == $past(cnt) + 1'b1));
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);
endmodule

// File: rtl/tdir_array.sv
module tdir_array
    import tdir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] rd_line,
    output dent_t             rd_ent,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  dent_t             wr_ent
);
    localparam int DEPTH = 1 << LINE_W;

    dent_t ents [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ents[i] <= '0;
        end else if (wr_en) begin
            ents[wr_line] <= wr_ent;
        end
    end

    assign rd_ent = ents[rd_line];

    // R6: an exclusive entry names exactly one holder, its owner
    a_r6_excl_single_holder: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_ent.st == DS_EXC) |->
            ($countones(wr_ent.sharers) == 1 && wr_ent.sharers[wr_ent.owner]));
endmodule

// File: rtl/tag_dir_slice.sv
module tag_dir_slice
    import tdir_pkg::*;
#(
    parameter int SLICE_ID = 0,
    parameter int QDEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [CORE_W-1:0]  req_core,
    input  logic [LINE_W-1:0]  req_line,
    input  logic               req_excl,
    output logic               mem_valid,
    output logic [MC_W-1:0]    mem_sel,
    output logic [LINE_W-1:0]  mem_line,
    input  logic               mem_ack,
    output logic               fwd_valid,
    output logic [CORE_W-1:0]  fwd_core,
    output logic [LINE_W-1:0]  fwd_line,
    output logic               fwd_excl,
    input  logic               fwd_ack,
    output logic               inv_valid,
    output logic [N_CORES-1:0] inv_mask,
    output logic [LINE_W-1:0]  inv_line,
    input  logic               inv_ack_valid,
    input  logic [CORE_W-1:0]  inv_ack_core,
    output logic               ack_valid,
    output logic [CORE_W-1:0]  ack_core,
    output logic [LINE_W-1:0]  ack_line,
    output logic               ack_excl
);
    typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WAIT} seq_e;

    seq_e               st;
    req_t               q_in, q_out, cur;
    logic               q_full, q_empty, push, pop, owns;
    dent_t              ent, fin_ent;
    logic [N_CORES-1:0] req_bit, holders, others, inv_pend;
    logic [CORE_W-1:0]  tgt, fwd_tgt;
    logic               need_mem, need_fwd, ack_q, done;

    // Ownership filter and pending queue
    assign owns = (slice_of(req_line) == SLICE_W'(SLICE_ID));
    assign push = req_valid && owns && !q_full;
    assign pop  = (st == ST_IDLE) && !q_empty;
    assign q_in = '{core: req_core, line: req_line, excl: req_excl};
    assign req_ready = !q_full;

    tdir_fifo #(.W($bits(req_t)), .DEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst(rst),
        .wr_en(push), .wr_data(q_in),
        .rd_en(pop),  .rd_data(q_out),
        .full(q_full), .empty(q_empty)
    );

    tdir_array u_track (
        .clk(clk), .rst(rst),
        .rd_line(cur.line), .rd_ent(ent),
        .wr_en(done), .wr_line(cur.line), .wr_ent(fin_ent)
    );

    // Source selection and next directory entry
    always_comb begin
        req_bit = N_CORES'(1) << cur.core;
        holders = (ent.st == DS_INV) ? '0 : ent.sharers;
        others  = holders & ~req_bit;
        tgt     = lowest_core(others);
        if (cur.excl) fin_ent = '{st: DS_EXC, owner: cur.core, sharers: req_bit};
        else          fin_ent = '{st: DS_SHR, owner: '0, sharers: holders | req_bit};
        done = (st == ST_WAIT) && !need_mem && !need_fwd && (inv_pend == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur      <= '0;
            need_mem <= 1'b0;
            need_fwd <= 1'b0;
            inv_pend <= '0;
            fwd_tgt  <= '0;
            ack_q    <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            case (st)
                ST_IDLE: if (!q_empty) begin
                    cur <= q_out;
                    st  <= ST_LOOK;
                end
                ST_LOOK: begin
                    need_mem <= (others == '0) && !(cur.excl && holders[cur.core]);
                    need_fwd <= (others != '0);
                    fwd_tgt  <= tgt;
                    inv_pend <= cur.excl ? (others & ~(N_CORES'(1) << tgt)) : '0;
                    st       <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_ack)       need_mem <= 1'b0;
                    if (fwd_ack)       need_fwd <= 1'b0;
                    if (inv_ack_valid) inv_pend[inv_ack_core] <= 1'b0;
                    if (done) begin
                        ack_q <= 1'b1;
                        st    <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_valid = (st == ST_WAIT) && need_mem;
    assign mem_sel   = mc_of(cur.line);
    assign mem_line  = cur.line;
    assign fwd_valid = (st == ST_WAIT) && need_fwd;
    assign fwd_core  = fwd_tgt;
    assign fwd_line  = cur.line;
    assign fwd_excl  = cur.excl;
    assign inv_valid = (st == ST_WAIT) && (inv_pend != '0);
    assign inv_mask  = inv_pend;
    assign inv_line  = cur.line;
    assign ack_valid = ack_q;
    assign ack_core  = cur.core;
    assign ack_line  = cur.line;
    assign ack_excl  = cur.excl;

    a_r4_single_source: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && fwd_valid));
    a_r4_fwd_not_self: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (fwd_core != cur.core));
    a_r5_inv_spares_req: assert property (@(posedge clk) disable iff (rst)
        inv_valid |-> (!inv_mask[cur.core] && !inv_mask[fwd_core]));
    a_r5_grant_after_acks: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> ($past(inv_pend) == '0 && !$past(need_mem) && !$past(need_fwd)));
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> !ack_valid);
endmodule

// File: tb/test_tag_dir_slice.sv
module test_tag_dir_slice;
    import tdir_pkg::*;

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 0, req_excl = 0, mem_ack = 0, fwd_ack = 0, inv_ack_valid = 0;
    logic [1:0] req_core = 0, inv_ack_core = 0;
    logic [7:0] req_line = 0;
    logic req_ready, mem_valid, fwd_valid, fwd_excl, inv_valid, ack_valid, ack_excl;
    logic [0:0] mem_sel;
    logic [1:0] fwd_core, ack_core;
    logic [3:0] inv_mask;
    logic [7:0] mem_line, fwd_line, inv_line, ack_line;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    tag_dir_slice i_tag_dir_slice (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
        .req_line(req_line), .req_excl(req_excl),
        .mem_valid(mem_valid), .mem_sel(mem_sel), .mem_line(mem_line), .mem_ack(mem_ack),
        .fwd_valid(fwd_valid), .fwd_core(fwd_core), .fwd_line(fwd_line),
        .fwd_excl(fwd_excl), .fwd_ack(fwd_ack),
        .inv_valid(inv_valid), .inv_mask(inv_mask), .inv_line(inv_line),
        .inv_ack_valid(inv_ack_valid), .inv_ack_core(inv_ack_core),
        .ack_valid(ack_valid), .ack_core(ack_core), .ack_line(ack_line), .ack_excl(ack_excl)
    );

    // {line, core, excl, src(0 mem,1 fwd,2 none), mc, fwd target, inv mask, pad}
    localparam int NV = 14;
    localparam logic [31:0] VEC [NV] = '{
        {8'h05, 2'd1, 1'b0, 2'd0, 1'b1, 2'd0, 4'h0, 12'h0},
        {8'h05, 2'd2, 1'b0, 2'd1, 1'b0, 2'd1, 4'h0, 12'h0},
        {8'h05, 2'd3, 1'b0, 2'd1, 1'b0, 2'd1, 4'h0, 12'h0},
        {8'h05, 2'd0, 1'b1, 2'd1, 1'b0, 2'd1, 4'hC, 12'h0},
        {8'h05, 2'd2, 1'b0, 2'd1, 1'b0, 2'd0, 4'h0, 12'h0},
        {8'h05, 2'd2, 1'b1, 2'd1, 1'b0, 2'd0, 4'h0, 12'h0},
        {8'h05, 2'd2, 1'b1, 2'd2, 1'b0, 2'd0, 4'h0, 12'h0},
        {8'h0A, 2'd3, 1'b1, 2'd0, 1'b0, 2'd0, 4'h0, 12'h0},
        {8'h0A, 2'd0, 1'b0, 2'd1, 1'b0, 2'd3, 4'h0, 12'h0},
        {8'h0F, 2'd1, 1'b1, 2'd0, 1'b1, 2'd0, 4'h0, 12'h0},
        {8'h33, 2'd2, 1'b0, 2'd0, 1'b1, 2'd0, 4'h0, 12'h0},
        {8'h33, 2'd3, 1'b1, 2'd1, 1'b0, 2'd2, 4'h0, 12'h0},
        {8'h0A, 2'd2, 1'b0, 2'd1, 1'b0, 2'd0, 4'h0, 12'h0},
        {8'h0A, 2'd1, 1'b1, 2'd1, 1'b0, 2'd0, 4'hC, 12'h0}
    };

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic drive_req(input int core, input int line, input int excl);
        @(negedge clk);
        req_core  = 2'(core);
        req_line  = 8'(line);
        req_excl  = 1'(excl);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Plays memory, supplier core and invalidated cores until the acknowledgement.
    task automatic serve_one(output int src, output int mc, output int tgt, output int inv,
                             output int a_core, output int a_line, output int a_excl,
                             output int ok, output int early);
        bit sm = 0, sf = 0, si = 0;
        logic [3:0] ip = 0;
        int sel;
        src = 2; mc = 0; tgt = 0; inv = 0; ok = 0; early = 0;
        a_core = -1; a_line = -1; a_excl = -1;
        for (int c = 0; c < 60 && ok == 0; c++) begin
            @(negedge clk);
            mem_ack = 0; fwd_ack = 0; inv_ack_valid = 0;
            if (ack_valid) begin
                ok = 1; a_core = ack_core; a_line = ack_line; a_excl = ack_excl;
                early = (ip != 0 || (fwd_valid && !sf)) ? 1 : 0;
            end else begin
                if (mem_valid && !sm) begin sm = 1; src = 0; mc = mem_sel; mem_ack = 1; end
                if (fwd_valid && !sf) begin sf = 1; src = 1; tgt = fwd_core; fwd_ack = 1; end
                if (inv_valid && !si) begin si = 1; ip = inv_mask; inv = inv_mask; end
                if (ip != 0) begin
                    sel = 0;
                    for (int k = 3; k >= 0; k--) if (ip[k]) sel = k;
                    inv_ack_core  = 2'(sel);
                    inv_ack_valid = 1;
                    ip[sel] = 1'b0;
                end
            end
        end
    endtask

    task automatic judge(input int core, input int line, input int excl, input int esrc,
                         input int emc, input int etgt, input int einv);
        int src, mc, tgt, inv, ac, al, ae, ok, early;
        string rs;
        serve_one(src, mc, tgt, inv, ac, al, ae, ok, early);
        rs = (esrc == 0) ? "R3" : (esrc == 1) ? "R4" : "R7";
        chk("R10", "ack seen", ok, 1);
        chk("R10", "ack core", ac, core);
        chk("R10", "ack line", al, line);
        chk("R10", "ack excl", ae, excl);
        chk(rs, "source", src, esrc);
        if (esrc == 0) chk("R2", "controller", mc, emc);
        if (esrc == 1) chk("R6", "forward target", tgt, etgt);
        chk("R5", "invalidate mask", inv, einv);
        chk("R5", "grant before acks", early, 0);
    endtask

    initial begin
        int bad;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9", "ready", req_ready, 1);
        chk("R9", "outputs idle", {ack_valid, mem_valid, fwd_valid, inv_valid}, 0);

        // Vector table: R3, R4, R5, R6, R7, R2, R10
        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            drive_req(v[23:22], v[31:24], v[21]);
            judge(v[23:22], v[31:24], v[21], v[20:19], v[18], v[17:16], v[15:12]);
        end

        // R1: line 0x30 hashes to slice 3 and must vanish
        drive_req(1, 8'h30, 0);
        bad = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (ack_valid || mem_valid || fwd_valid || inv_valid) bad++;
        end
        chk("R1", "foreign activity", bad, 0);

        // R8: five back-to-back requests to line 0x00, queue fills
        begin
            int qc [5] = '{1, 2, 3, 0, 1};
            int qx [5] = '{0, 0, 1, 0, 1};
            bad = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (!req_ready) bad++;
                req_core = 2'(qc[i]); req_line = 8'h00; req_excl = 1'(qx[i]); req_valid = 1'b1;
            end
            @(negedge clk);
            req_valid = 1'b0;
            chk("R8", "ready while filling", bad, 0);
            chk("R8", "ready when full", req_ready, 0);
            judge(1, 8'h00, 0, 0, 0, 0, 4'h0);
            judge(2, 8'h00, 0, 1, 0, 1, 4'h0);
            judge(3, 8'h00, 1, 1, 0, 1, 4'h4);
            judge(0, 8'h00, 0, 1, 0, 3, 4'h0);
            judge(1, 8'h00, 1, 1, 0, 0, 4'h8);
            @(negedge clk);
            chk("R8", "ready after drain", req_ready, 1);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule